// File: doc/BRIEF.md
# Recirculating Column Routing Channel

This block is one column of a time-slot routing channel for an array of processing nodes. It holds L = N_ITEMS * COPY word slots in a chain of registers that advances by one position per clock. At the start of a period the chain is filled from the top. The first column takes N_ITEMS primary words and places each one in COPY consecutive slots. A later column takes one word per slot from the column before it. Once the chain is full, the top input is switched to the word leaving the bottom of the chain, so the contents keep rotating.

Nodes attached to the chain see every slot through read taps. During the write phase a node may put its own word in place of the word that would move into its slot position. A period lasts 3L advancing cycles: L cycles to load, L cycles in which the nodes read and compute, and L cycles in which they write. When the period ends, the complete contents are offered to the next column, and the next batch starts loading at once.

A cycle counter and a phase code are exported so that nodes can work out which slot passes them in each cycle. Loading waits on a valid/ready handshake. The processing and write phases never stall.

Top module: `col_route_channel`

## Requirements
- R1: While rst_n is low, and after it is released until a start pulse arrives, phase_o is 0 (idle), cyc_cnt_o is 0, in_ready_o is 0, hand_valid_o is 0 and every slot holds 0.
- R2: A start_i pulse while idle puts the block in phase 1 (load) with cyc_cnt_o = 0 on the next cycle. start_i is ignored while a period is running.
- R3: In phase 1, in_ready_o is high exactly when a fresh input word is needed, that is, on the first of each group of COPY slots. An accepted word fills COPY consecutive slots, and in_data_i is ignored on the repeat cycles. After L load steps, slot i (bits i*DW and up of slots_o) holds the word that entered at step L-1-i.
- R4: In phase 1, while in_ready_o is high and in_valid_i is low, neither cyc_cnt_o nor any slot changes.
- R5: cyc_cnt_o rises by one on every advancing cycle and wraps from 3L-1 to 0. phase_o is 1 for counts below L, 2 (process) for counts L to 2L-1, and 3 (write) for counts 2L to 3L-1.
- R6: In phases 2 and 3, slot 0 takes the word leaving slot L-1, so after the L cycles of phase 2 the slot contents equal those at the end of loading.
- R7: In phase 3, when wr_en_i[i] is high, slot i takes wr_data_i[i*DW +: DW] in place of its upstream word. This includes slot 0, where the write wins over the feedback word. wr_en_i has no effect in any other phase.
- R8: hand_valid_o is high for exactly one cycle, the cycle after the count wraps. In that cycle cyc_cnt_o is 0, phase_o is 1, and slots_o holds the contents after all 3L steps, writes included. Without stalls, successive pulses are 3L cycles apart.
- R9: The next batch loads right after a hand-off. The old contents shift out of slot L-1, and after L load steps the slots hold only the new batch in the R3 arrangement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begins the first period when idle |
| in_valid_i | input | 1 | Input word available |
| in_ready_o | output | 1 | Channel wants a fresh input word |
| in_data_i | input | DW | Input word (primary data or previous column) |
| wr_en_i | input | L | Per-slot write request from nodes |
| wr_data_i | input | L*DW | Per-slot write words, slot i at bits i*DW |
| slots_o | output | L*DW | Read taps and hand-off bus, slot i at bits i*DW |
| cyc_cnt_o | output | $clog2(3L) | Position within the period |
| phase_o | output | 2 | 0 idle, 1 load, 2 process, 3 write |
| hand_valid_o | output | 1 | Contents ready for the next column |

## Verification
Two collisions are provoked. The first is a node write to slot 0 on the last write cycle, at count 3L-1. That write competes with the feedback word for the top slot in the same cycle that the count wraps and the hand-off is raised. The bench expects the hand-off to carry the written word in slot 0 and the rest of the period's result unchanged. The second is a start pulse and write requests issued in phases where they must do nothing. These are judged by comparing the count, each slot and the hand-off spacing with a slot model kept from the requirements.

// File: rtl/col_route_pkg.sv
// Shared types for the column routing channel.
// Assumes nothing beyond a 2-bit phase code shared by all submodules.
package col_route_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOAD  = 2'd1,
        PH_PROC  = 2'd2,
        PH_WRITE = 2'd3
    } phase_e;
endpackage

// File: rtl/crc_period_timer.sv
// Period timer: holds the run flag, counts advancing cycles from 0 to
// 3L-1 and decodes the phase. It also pulses the hand-off flag after a wrap.
// Assumes step_i is only high while running.
module crc_period_timer
    import col_route_pkg::*;
#(
    parameter int L  = 8,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          step_i,
    output logic [CW-1:0] cnt_o,
    output phase_e        phase_o,
    output logic          hand_valid_o
);
    localparam int LAST = 3 * L - 1;

    logic running;

    // Run flag, period counter and hand-off pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running      <= 1'b0;
            cnt_o        <= '0;
            hand_valid_o <= 1'b0;
        end else begin
            hand_valid_o <= 1'b0;
            if (!running) begin
                running <= start_i;
                cnt_o   <= '0;
            end else if (step_i) begin
                if (cnt_o == CW'(LAST)) begin
                    cnt_o        <= '0;
                    hand_valid_o <= 1'b1;
                end else begin
                    cnt_o <= cnt_o + 1'b1;
                end
            end
        end
    end

    // Phase decode from the count.
    always_comb begin
        if (!running)                 phase_o = PH_IDLE;
        else if (cnt_o < CW'(L))      phase_o = PH_LOAD;
        else if (cnt_o < CW'(2 * L))  phase_o = PH_PROC;
        else                          phase_o = PH_WRITE;
    end
endmodule

// File: rtl/crc_feeder.sv
// Top-of-column feeder: picks the word entering slot 0 and decides whether
// the chain advances. While loading, it repeats each accepted word COPY times
// and stalls on missing input. Otherwise it feeds back the bottom slot.
// Assumes COPY >= 1.
module crc_feeder
    import col_route_pkg::*;
#(
    parameter int DW   = 8,
    parameter int COPY = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        phase_i,
    input  logic          in_valid_i,
    input  logic [DW-1:0] in_data_i,
    input  logic [DW-1:0] recirc_i,
    output logic          in_ready_o,
    output logic          step_o,
    output logic [DW-1:0] top_o
);
    logic          need_new;
    logic [DW-1:0] hold;
    logic          loading;

    assign loading = (phase_i == PH_LOAD);

    generate
        if (COPY > 1) begin : g_repeat
            localparam int RW = $clog2(COPY);
            logic [RW-1:0] rep;

            assign need_new = (rep == '0);

            // Repeat counter and held word for the COPY-1 repeat slots.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rep  <= '0;
                    hold <= '0;
                end else if (loading && step_o) begin
                    if (need_new) hold <= in_data_i;
                    rep <= (rep == RW'(COPY - 1)) ? '0 : rep + 1'b1;
                end
            end
        end else begin : g_single
            assign need_new = 1'b1;
            assign hold     = '0;
        end
    endgenerate

    // Handshake, advance decision and top word selection.
    always_comb begin
        in_ready_o = loading && need_new;
        if (loading)
            step_o = !need_new || in_valid_i;
        else
            step_o = (phase_i != PH_IDLE);
        if (loading)
            top_o = need_new ? in_data_i : hold;
        else
            top_o = recirc_i;
    end
endmodule

// File: rtl/crc_slot_chain.sv
// Slot chain: L registers of DW bits. When stepping, each register takes its
// upstream neighbour, or the node's word when a write is allowed and requested.
// Assumes wr_act_i is only high in the write phase.
module crc_slot_chain #(
    parameter int DW = 8,
    parameter int L  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_i,
    input  logic            wr_act_i,
    input  logic [DW-1:0]   top_i,
    input  logic [L-1:0]    wr_en_i,
    input  logic [L*DW-1:0] wr_data_i,
    output logic [L*DW-1:0] slots_o
);
    generate
        for (genvar i = 0; i < L; i++) begin : g_slot
            logic [DW-1:0] up;
            logic [DW-1:0] q;

            if (i == 0) begin : g_head
                assign up = top_i;
            end else begin : g_body
                assign up = slots_o[(i-1)*DW +: DW];
            end

            // One slot register with its write-override mux.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (step_i)
                    q <= (wr_act_i && wr_en_i[i]) ? wr_data_i[i*DW +: DW] : up;
            end

            assign slots_o[i*DW +: DW] = q;
        end
    endgenerate
endmodule

// File: rtl/col_route_channel.sv
// One column of the recirculating routing channel. It ties the timer, the
// feeder and the slot chain together. FIRST_COL=1 repeats each input word
// COPY times; FIRST_COL=0 takes one word per slot from the previous column.
// Assumes the next column samples slots_o while hand_valid_o is high.
module col_route_channel
    import col_route_pkg::*;
#(
    parameter int  DW        = 8,
    parameter int  N_ITEMS   = 4,
    parameter int  COPY      = 2,
    parameter bit  FIRST_COL = 1'b1,
    localparam int L         = N_ITEMS * COPY,
    localparam int CW        = $clog2(3 * L)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            in_valid_i,
    output logic            in_ready_o,
    input  logic [DW-1:0]   in_data_i,
    input  logic [L-1:0]    wr_en_i,
    input  logic [L*DW-1:0] wr_data_i,
    output logic [L*DW-1:0] slots_o,
    output logic [CW-1:0]   cyc_cnt_o,
    output logic [1:0]      phase_o,
    output logic            hand_valid_o
);
    localparam int REP = FIRST_COL ? COPY : 1;

    phase_e        phase;
    logic          step;
    logic [DW-1:0] top_word;

    assign phase_o = phase;

    crc_period_timer #(.L(L), .CW(CW)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .step_i       (step),
        .cnt_o        (cyc_cnt_o),
        .phase_o      (phase),
        .hand_valid_o (hand_valid_o)
    );

    crc_feeder #(.DW(DW), .COPY(REP)) u_feed (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_i    (phase),
        .in_valid_i (in_valid_i),
        .in_data_i  (in_data_i),
        .recirc_i   (slots_o[(L-1)*DW +: DW]),
        .in_ready_o (in_ready_o),
        .step_o     (step),
        .top_o      (top_word)
    );

    crc_slot_chain #(.DW(DW), .L(L)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step),
        .wr_act_i  (phase == PH_WRITE),
        .top_i     (top_word),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .slots_o   (slots_o)
    );
endmodule

// File: rtl/col_route_checker.sv
// Property checker for col_route_channel, attached by bind below.
module col_route_checker #(
    parameter int DW = 8,
    parameter int L  = 8,
    parameter int CW = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid_i,
    input logic            in_ready_o,
    input logic [L-1:0]    wr_en_i,
    input logic [L*DW-1:0] wr_data_i,
    input logic [L*DW-1:0] slots_o,
    input logic [CW-1:0]   cyc_cnt_o,
    input logic [1:0]      phase_o,
    input logic            hand_valid_o
);
    localparam logic [CW-1:0] LAST = CW'(3 * L - 1);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd0) |-> (!in_ready_o && cyc_cnt_o == '0));

    p_ready_in_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> (phase_o == 2'd1));

    p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd1 && in_ready_o && !in_valid_i)
        |=> ($stable(cyc_cnt_o) && $stable(slots_o)));

    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd2 || phase_o == 2'd3)
        |=> (cyc_cnt_o == (($past(cyc_cnt_o) == LAST) ? '0 : $past(cyc_cnt_o) + 1'b1)));

    p_proc_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd2) |-> (cyc_cnt_o >= CW'(L) && cyc_cnt_o < CW'(2 * L)));

    p_feedback_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd2) |=> (slots_o[DW-1:0] == $past(slots_o[L*DW-1 -: DW])));

    p_head_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd3 && wr_en_i[0]) |=> (slots_o[DW-1:0] == $past(wr_data_i[DW-1:0])));

    p_handoff_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hand_valid_o |-> (cyc_cnt_o == '0 && phase_o == 2'd1));

    p_handoff_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hand_valid_o |=> !hand_valid_o);
endmodule

bind col_route_channel col_route_checker #(.DW(DW), .L(L), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid_i   (in_valid_i),
    .in_ready_o   (in_ready_o),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .slots_o      (slots_o),
    .cyc_cnt_o    (cyc_cnt_o),
    .phase_o      (phase_o),
    .hand_valid_o (hand_valid_o)
);

// File: tb/col_route_channel_bench.sv
// Directed bench for col_route_channel; a slot model is kept from the requirements.
module col_route_channel_bench;
    localparam int DW = 8;
    localparam int N  = 4;
    localparam int C  = 2;
    localparam int L  = N * C;
    localparam int CW = $clog2(3 * L);
    localparam int P  = 3 * L;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            start_i;
    logic            in_valid_i;
    logic            in_ready_o;
    logic [DW-1:0]   in_data_i;
    logic [L-1:0]    wr_en_i;
    logic [L*DW-1:0] wr_data_i;
    logic [L*DW-1:0] slots_o;
    logic [CW-1:0]   cyc_cnt_o;
    logic [1:0]      phase_o;
    logic            hand_valid_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int hand_at[2];
    logic [DW-1:0] m [L];

    col_route_channel #(.DW(DW), .N_ITEMS(N), .COPY(C)) u_col_route_channel (.*);

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_slots(input string tag);
        for (int i = 0; i < L; i++)
            chk($sformatf("%s slot%0d", tag, i), int'(slots_o[i*DW +: DW]), int'(m[i]));
    endtask

    task automatic model_step(input logic [DW-1:0] top, input bit wr_ok);
        logic [DW-1:0] nx [L];
        for (int i = 0; i < L; i++) begin
            nx[i] = (i == 0) ? top : m[i-1];
            if (wr_ok && wr_en_i[i]) nx[i] = wr_data_i[i*DW +: DW];
        end
        for (int i = 0; i < L; i++) m[i] = nx[i];
    endtask

    task automatic t_reset();
        rst_n = 1'b0; start_i = 1'b0; in_valid_i = 1'b0; in_data_i = '0;
        wr_en_i = '0; wr_data_i = '0;
        for (int i = 0; i < L; i++) m[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1 phase in reset", int'(phase_o), 0);
        chk("R1 count in reset", int'(cyc_cnt_o), 0);
        chk("R1 ready in reset", int'(in_ready_o), 0);
        chk("R1 hand in reset", int'(hand_valid_o), 0);
        chk_slots("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", int'(phase_o), 0);
    endtask

    task automatic t_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 phase after start", int'(phase_o), 1);
        chk("R2 count after start", int'(cyc_cnt_o), 0);
    endtask

    task automatic t_load(input logic [DW-1:0] base, input bit do_stall, input string tag);
        int s = 0;
        for (int j = 0; j < N; j++) begin
            for (int k = 0; k < C; k++) begin
                chk($sformatf("R3 ready %s j%0d k%0d", tag, j, k), int'(in_ready_o), (k == 0) ? 1 : 0);
                if (do_stall && j == 1 && k == 0) begin
                    in_valid_i = 1'b0;
                    for (int r = 0; r < 3; r++) begin
                        @(negedge clk);
                        chk("R4 count held in stall", int'(cyc_cnt_o), s);
                        chk("R4 ready held in stall", int'(in_ready_o), 1);
                    end
                    chk_slots("R4 slots held in stall");
                end
                in_valid_i = (k == 0);
                in_data_i  = (k == 0) ? base + DW'(j * 17) : 8'h5A;
                start_i    = (do_stall && j == 2 && k == 1);
                model_step(base + DW'(j * 17), 1'b0);
                @(negedge clk);
                start_i = 1'b0;
                s++;
                chk($sformatf("R5 count %s step%0d", tag, s), int'(cyc_cnt_o), s);
                chk("R8 hand low while loading", int'(hand_valid_o), 0);
            end
        end
        in_valid_i = 1'b0;
        chk($sformatf("R5 phase process %s", tag), int'(phase_o), 2);
        chk("R3 ready low after load", int'(in_ready_o), 0);
        chk_slots($sformatf("R3 R9 loaded %s", tag));
    endtask

    task automatic t_circulate();
        for (int s = 0; s < L; s++) begin
            chk("R5 phase in process", int'(phase_o), 2);
            wr_en_i = '0;
            wr_en_i[3] = 1'b1;
            wr_data_i[3*DW +: DW] = 8'hEE;
            model_step(m[L-1], 1'b0);
            @(negedge clk);
        end
        wr_en_i = '0;
        chk("R5 phase write", int'(phase_o), 3);
        chk("R5 count at write start", int'(cyc_cnt_o), 2 * L);
        chk_slots("R6 R7 after circulation");
    endtask

    task automatic t_write(input int idx);
        for (int s = 0; s < L; s++) begin
            chk("R8 hand low in write phase", int'(hand_valid_o), 0);
            wr_en_i = '0;
            if (s == 0) begin
                wr_en_i[5] = 1'b1;
                wr_data_i[5*DW +: DW] = 8'h5C;
            end
            if (s == L - 1) begin
                wr_en_i[0] = 1'b1;
                wr_data_i[0 +: DW] = 8'hC0;
            end
            model_step(m[L-1], 1'b1);
            @(negedge clk);
        end
        wr_en_i = '0;
        hand_at[idx] = cyc;
        chk("R8 hand pulse", int'(hand_valid_o), 1);
        chk("R8 count at hand-off", int'(cyc_cnt_o), 0);
        chk("R8 phase at hand-off", int'(phase_o), 1);
        chk("R7 head write beats feedback", int'(slots_o[0 +: DW]), 8'hC0);
        chk_slots("R7 R8 hand-off");
    endtask

    initial begin
        t_reset();
        t_start();
        t_load(8'h11, 1'b1, "A");
        t_circulate();
        t_write(0);
        t_load(8'hA1, 1'b0, "B");
        t_circulate();
        t_write(1);
        chk("R8 hand-off spacing", hand_at[1] - hand_at[0], P);
        @(negedge clk);
        chk("R8 hand single cycle", int'(hand_valid_o), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule